// File: doc/BRIEF.md
# Page-Mode EEPROM Write Controller

This block is the device-side control of a byte-wide, page-programmed nonvolatile memory, written as a clocked and synthesizable model. The chip-enable, write-enable and output-enable strobes, the address and the data are sampled on the system clock. A qualified write pulse stores one byte into a page buffer. Each write restarts a load window, and while that window stays open further bytes join the same page. When the window closes without a new write, a programming period of fixed length starts. During it the buffered bytes are copied into the backing array, and bytes that were not loaded keep their old values.

While a page is loading or programming, every read returns a polling status: the last byte written, with its most significant bit inverted. Software polls until it sees true data again, and then it may issue the next access. Pulses shorter than a parameterised number of samples are treated as noise. A write pulse that overlaps a low output enable is discarded.

Top module: `eep_page_writer`

## Requirements
- R1: During and right after reset, `dout_oe` is 0 and `dout` is 0.
- R2: `dout_oe` is 1 exactly when chip enable and output enable were both low and write enable high at the input sample two clocks earlier; `dout` is valid in those cycles.
- R3: A write is taken only when `oe_n` stays high for the whole pulse and is still high when the pulse ends. A pulse during which `oe_n` is low loads nothing and starts no programming.
- R4: A write pulse is the overlap of low `ce_n` and low `we_n`. It counts only if it lasts at least GLITCH_MIN clock samples; a shorter pulse has no effect.
- R5: The byte address is taken at the first sample of the pulse. The data is the value sampled last before the pulse ends.
- R6: Address bits [PAGE_W-1:0] pick the byte within a page. The upper bits of the first byte loaded fix the page used for the whole commit, and later bytes are placed at their offset within that page.
- R7: Every qualified write pulse restarts the load window. Programming starts BLC_CYC clocks after the last pulse ends.
- R8: Programming lasts PROG_CYC clocks, whatever the number of bytes loaded. With the read strobe held, true data appears on the (BLC_CYC+PROG_CYC+3)-th falling clock edge after the edge where the write pulse was released.
- R9: From the first write of a page until programming ends, a read of any address returns the last byte written with bit 7 inverted.
- R10: Bytes of the committed page that were not loaded keep their previous contents.
- R11: Write pulses that arrive during the programming period are ignored.
- R12: A pulse controlled by chip enable (write enable already low, chip enable pulsed) writes in the same way as one controlled by write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or polling status |
| dout_oe | output | 1 | High when `dout` should be driven onto the bus |

## Verification
If the load timer or the programming counter is off by one, the release of polling status moves by a cycle, and the exact-edge check after a single write reports it. If the page-address latch or the byte-valid mask is corrupted, bytes land in the wrong page or unloaded bytes get overwritten, and this is seen on the first read after the commit. A filter, inhibit or busy-ignore path that is broken shows up at once: the next read returns polling status where true data is expected, or the wrong value appears after the following commit.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eep_state_e;

endpackage

// File: rtl/eep_strobe_filter.sv
module eep_strobe_filter #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int GLITCH_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] s_addr,
  output logic              rd_en,
  output logic              fire,
  output logic              armed,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data
);

  localparam int RW = $clog2(GLITCH_MIN + 1) + 1;
  localparam logic [RW-1:0] G_LIM  = RW'(GLITCH_MIN);
  localparam logic [RW-1:0] G_ARM  = RW'(GLITCH_MIN - 1);

  logic              s_ce_n, s_we_n, s_oe_n;
  logic [DATA_W-1:0] s_din;
  logic              act, prev_act;
  logic [RW-1:0]     run_q, run_d;
  logic [ADDR_W-1:0] a_hold_q, a_hold_d;
  logic [DATA_W-1:0] d_hold_q, d_hold_d;

  // input sampling stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce_n <= 1'b1;
      s_we_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ce_n <= ce_n;
      s_we_n <= we_n;
      s_oe_n <= oe_n;
      s_addr <= addr;
      s_din  <= din;
    end
  end

  assign act   = !s_ce_n && !s_we_n && s_oe_n;
  assign rd_en = !s_ce_n && !s_oe_n && s_we_n;

  always_comb begin
    run_d    = run_q;
    a_hold_d = a_hold_q;
    d_hold_d = d_hold_q;
    if (act) begin
      if (run_q < G_LIM) run_d = run_q + 1'b1;
      if (!prev_act) a_hold_d = s_addr;
      d_hold_d = s_din;
    end else begin
      run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act <= 1'b0;
      run_q    <= '0;
      a_hold_q <= '0;
      d_hold_q <= '0;
    end else begin
      prev_act <= act;
      run_q    <= run_d;
      a_hold_q <= a_hold_d;
      d_hold_q <= d_hold_d;
    end
  end

  assign fire    = prev_act && !act && s_oe_n && (run_q >= G_LIM);
  assign armed   = act && (run_q >= G_ARM);
  assign ld_addr = a_hold_q;
  assign ld_data = d_hold_q;

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     first,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     clear,
  input  logic [PAGE_W-1:0]        rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic [ADDR_W-PAGE_W-1:0] page,
  output logic [DATA_W-1:0]        last_data
);

  localparam int DEPTH = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [DEPTH-1:0]  mask_q, mask_d;
  logic [DATA_W-1:0] bytes_q [DEPTH];
  logic [PAGE_W-1:0] off;
  logic [PG_W-1:0]   page_q;
  logic [DATA_W-1:0] last_q;

  assign off = wr_addr[PAGE_W-1:0];

  // per-byte storage with its own clock enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic hit;
    assign hit = we && (off == PAGE_W'(g));
    always_ff @(posedge clk) begin
      if (hit) bytes_q[g] <= wr_data;
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (clear) mask_d = '0;
    else if (we) mask_d[off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      page_q <= '0;
      last_q <= '0;
    end else begin
      mask_q <= mask_d;
      if (we && first) page_q <= wr_addr[ADDR_W-1:PAGE_W];
      if (we) last_q <= wr_data;
    end
  end

  assign rd_data   = bytes_q[rd_idx];
  assign rd_valid  = mask_q[rd_idx];
  assign page      = page_q;
  assign last_data = last_q;

endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq
  import eep_pkg::*;
#(
  parameter int PAGE_W   = 7,
  parameter int BLC_CYC  = 64,
  parameter int PROG_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              armed,
  output eep_state_e        state,
  output logic              buf_we,
  output logic              first,
  output logic              sweep_en,
  output logic [PAGE_W-1:0] sweep_idx,
  output logic              clear,
  output logic              busy
);

  localparam int TW = $clog2(BLC_CYC + 1);
  localparam int PW = $clog2(PROG_CYC + 1) + 1;
  localparam logic [TW-1:0] T_END = TW'(BLC_CYC - 1);
  localparam logic [PW-1:0] P_END = PW'(PROG_CYC - 1);
  localparam logic [PW-1:0] P_PG  = PW'(1 << PAGE_W);

  eep_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    pc_d  = pc_q;
    unique case (st_q)
      ST_IDLE: begin
        if (fire) begin
          st_d  = ST_LOAD;
          tmr_d = '0;
        end
      end
      ST_LOAD: begin
        if (fire || armed) begin
          tmr_d = '0;
        end else if (tmr_q == T_END) begin
          st_d = ST_PROG;
          pc_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_PROG: begin
        if (pc_q == P_END) st_d = ST_IDLE;
        else pc_d = pc_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      pc_q  <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      pc_q  <= pc_d;
    end
  end

  assign state     = st_q;
  assign buf_we    = fire && (st_q != ST_PROG);
  assign first     = (st_q == ST_IDLE);
  assign sweep_en  = (st_q == ST_PROG) && (pc_q < P_PG);
  assign sweep_idx = PAGE_W'(pc_q);
  assign clear     = (st_q == ST_PROG) && (pc_q == P_END);
  assign busy      = (st_q != ST_IDLE);

endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
  import eep_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 7,
  parameter int DATA_W     = 8,
  parameter int GLITCH_MIN = 3,
  parameter int BLC_CYC    = 64,
  parameter int PROG_CYC   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  localparam int PG_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] s_addr, ld_addr;
  logic [DATA_W-1:0] ld_data, pb_data, last_data, arr_rdata, poll;
  logic              rd_en, fire, armed;
  eep_state_e        seq_state;
  logic              buf_we, first, sweep_en, clear, busy, pb_valid, arr_we;
  logic [PAGE_W-1:0] sweep_idx;
  logic [PG_W-1:0]   page;
  logic [DATA_W-1:0] dout_d;

  eep_strobe_filter #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_MIN(GLITCH_MIN)
  ) u_filt (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .s_addr(s_addr), .rd_en(rd_en),
    .fire(fire), .armed(armed), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  eep_prog_seq #(
    .PAGE_W(PAGE_W), .BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .armed(armed),
    .state(seq_state), .buf_we(buf_we), .first(first),
    .sweep_en(sweep_en), .sweep_idx(sweep_idx), .clear(clear), .busy(busy)
  );

  eep_page_buf #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
  ) u_pbuf (
    .clk(clk), .rst_n(rst_n), .we(buf_we), .first(first),
    .wr_addr(ld_addr), .wr_data(ld_data), .clear(clear),
    .rd_idx(sweep_idx), .rd_data(pb_data), .rd_valid(pb_valid),
    .page(page), .last_data(last_data)
  );

  assign arr_we = sweep_en && pb_valid;

  eep_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_arr (
    .clk(clk), .we(arr_we), .waddr({page, sweep_idx}), .wdata(pb_data),
    .raddr(s_addr), .rdata(arr_rdata)
  );

  assign poll = {~last_data[DATA_W-1], last_data[DATA_W-2:0]};

  always_comb begin
    dout_d = busy ? poll : arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_en;
      if (rd_en) dout <= dout_d;
    end
  end

endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk
  import eep_pkg::*;
#(
  parameter int GLITCH_MIN = 3,
  parameter int PROG_CYC   = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       dout_oe,
  input logic       fire,
  input logic       buf_we,
  input logic       arr_we,
  input eep_state_e seq_state
);

  localparam int PW = $clog2(PROG_CYC + 2) + 1;
  localparam logic [PW-1:0] P_LEN = PW'(PROG_CYC);
  localparam logic [7:0]    G_LEN = 8'(GLITCH_MIN);

  logic [7:0]    run;
  logic [PW-1:0] pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
      pc  <= '0;
    end else begin
      if (!ce_n && !we_n && oe_n) begin
        if (run != 8'hFF) run <= run + 1'b1;
      end else begin
        run <= '0;
      end
      if (seq_state == ST_PROG) pc <= pc + 1'b1;
      else pc <= '0;
    end
  end

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(!ce_n && !oe_n && we_n, 2)); // R2
  AST_WRITE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(oe_n)); // R3
  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($past(run) >= G_LEN)); // R4
  AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != ST_PROG && pc != '0) |-> (pc == P_LEN)); // R8
  AST_ARRAY_ONLY_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (seq_state == ST_PROG)); // R10
  AST_NO_LOAD_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_PROG) |-> !buf_we); // R11

endmodule

bind eep_page_writer eep_page_writer_chk #(
  .GLITCH_MIN(GLITCH_MIN), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .dout_oe(dout_oe), .fire(fire), .buf_we(buf_we), .arr_we(arr_we),
  .seq_state(seq_state)
);

// File: tb/eep_page_writer_bench.sv
module eep_page_writer_bench;

  localparam int AW   = 10;
  localparam int DW   = 8;
  localparam int BLC  = 64;
  localparam int PROG = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  eep_page_writer u_eep_page_writer (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0;
    nclk(1); we_n = 1'b0;
    nclk(len); we_n = 1'b1;
    nclk(1); ce_n = 1'b1;
    nclk(1);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v, output logic o);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    nclk(3);
    v = dout; o = dout_oe;
    bus_idle();
    nclk(1);
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    logic o;
    rd(a, v, o);
    chk(req, v, exp);
  endtask

  task automatic wait_done();
    nclk(BLC + PROG + 8);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    nclk(5);
    chk("R1 dout_oe in reset", {7'd0, dout_oe}, 8'h00);
    chk("R1 dout in reset", dout, 8'h00);
    rst_n = 1'b1;
    nclk(2);
    chk("R1 dout_oe after reset", {7'd0, dout_oe}, 8'h00);
  endtask

  task automatic t_read_gate();
    addr = 10'h080; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    nclk(3);
    chk("R2 read enables output", {7'd0, dout_oe}, 8'h01);
    ce_n = 1'b1;
    nclk(3);
    chk("R2 ce high gives hi-z", {7'd0, dout_oe}, 8'h00);
    ce_n = 1'b0; oe_n = 1'b1;
    nclk(3);
    chk("R2 oe high gives hi-z", {7'd0, dout_oe}, 8'h00);
    bus_idle();
    nclk(2);
  endtask

  task automatic t_single();
    addr = 10'h012; din = 8'hA5; oe_n = 1'b1; ce_n = 1'b0;
    nclk(1); we_n = 1'b0;
    nclk(3); we_n = 1'b1;
    nclk(1); oe_n = 1'b0;
    nclk(BLC + PROG + 1);
    chk("R8 R9 polling on last busy edge", dout, 8'h25);
    nclk(1);
    chk("R8 true data on exact edge", dout, 8'hA5);
    bus_idle();
    nclk(1);
  endtask

  task automatic t_poll_other();
    wr(10'h040, 8'h3C, 3);
    rd_chk("R9 poll from other address", 10'h100, 8'hBC);
    wait_done();
    rd_chk("R9 true data after programming", 10'h040, 8'h3C);
  endtask

  task automatic t_data_late();
    addr = 10'h050; din = 8'h11; oe_n = 1'b1; ce_n = 1'b0;
    nclk(1); we_n = 1'b0;
    nclk(1); din = 8'h77; addr = 10'h0D3;
    nclk(2); we_n = 1'b1;
    nclk(1); ce_n = 1'b1;
    nclk(1);
    wait_done();
    rd_chk("R5 first address, last data", 10'h050, 8'h77);
  endtask

  task automatic t_page();
    int errs;
    logic [DW-1:0] v;
    logic o;
    wr(10'h28A, 8'h66, 3);
    wait_done();
    for (int i = 0; i < 128; i++) wr(AW'(10'h080 + i), 8'(i) ^ 8'h5A, 3);
    wait_done();
    errs = 0;
    for (int i = 0; i < 128; i++) begin
      rd(AW'(10'h080 + i), v, o);
      if (v !== (8'(i) ^ 8'h5A)) errs++;
    end
    chk("R6 full page mismatches", 8'(errs), 8'h00);
    wr(10'h083, 8'hC3, 3);
    wr(10'h28A, 8'h9E, 3);
    wait_done();
    rd_chk("R6 first byte of partial page", 10'h083, 8'hC3);
    rd_chk("R6 later byte goes to first page", 10'h08A, 8'h9E);
    rd_chk("R6 other page untouched", 10'h28A, 8'h66);
    rd_chk("R10 unloaded byte keeps value", 10'h084, 8'h5E);
  endtask

  task automatic t_retrig();
    logic [DW-1:0] v;
    logic o;
    wr(10'h100, 8'h01, 3);
    nclk(40);
    wr(10'h101, 8'h02, 3);
    rd(10'h300, v, o);
    chk("R7 R9 still loading between writes", v, 8'h82);
    nclk(36);
    wr(10'h102, 8'h03, 3);
    wait_done();
    rd_chk("R7 late byte joins page", 10'h102, 8'h03);
    rd_chk("R7 first byte committed", 10'h100, 8'h01);
  endtask

  task automatic t_glitch();
    wr(10'h085, 8'hFF, 2);
    rd_chk("R4 short pulse leaves no busy", 10'h085, 8'h5F);
    nclk(BLC + PROG);
    rd_chk("R4 short pulse writes nothing", 10'h085, 8'h5F);
  endtask

  task automatic t_inhibit();
    addr = 10'h086; din = 8'h00; oe_n = 1'b0; ce_n = 1'b0;
    nclk(1); we_n = 1'b0;
    nclk(4); we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    nclk(1);
    rd_chk("R3 inhibited pulse leaves no busy", 10'h086, 8'h5C);
    nclk(BLC + PROG);
    rd_chk("R3 inhibited pulse writes nothing", 10'h086, 8'h5C);
  endtask

  task automatic t_busy_ignore();
    wr(10'h087, 8'h01, 3);
    nclk(BLC + 20);
    wr(10'h088, 8'hEE, 3);
    wait_done();
    rd_chk("R11 first write committed", 10'h087, 8'h01);
    rd_chk("R11 write during programming ignored", 10'h088, 8'h52);
  endtask

  task automatic t_ce_ctrl();
    addr = 10'h089; din = 8'h44; oe_n = 1'b1; we_n = 1'b0;
    nclk(1); ce_n = 1'b0;
    nclk(3); ce_n = 1'b1;
    nclk(1); we_n = 1'b1;
    nclk(1);
    wait_done();
    rd_chk("R12 chip-enable controlled write", 10'h089, 8'h44);
  endtask

  initial begin
    nclk(200000);
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_read_gate();
    t_single();
    t_poll_other();
    t_data_late();
    t_page();
    t_retrig();
    t_glitch();
    t_inhibit();
    t_busy_ignore();
    t_ce_ctrl();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule